// File: doc/BRIEF.md
# Pulse-Swallow Programmable Divider

This block divides an already prescaled clock by a programmable 15-bit ratio N and emits one single-cycle pulse every N input cycles. That pulse is the feedback edge a phase detector compares against its reference. The division is built from three cooperating pieces instead of one wide down-counter. A dual-modulus stage counts 32 or 33 input cycles. A 10-bit main counter takes the upper ten bits of N and counts completed modulus cycles. A 5-bit swallow counter takes the lower five bits and holds the stage at 33 until it runs out.

With M = N[14:5] and S = N[4:0], one output period lasts S stages of 33 cycles followed by M−S stages of 32 cycles, which totals 32·M + S = N. The smallest accepted ratio is 1024, so M is always at least 32 and therefore larger than any S. A ratio below that floor is raised to 1024. A new ratio is taken only at the end of an output period, so a control write never yields a truncated or stretched period.

Top module: `pulse_swallow_divider`

## Requirements
- R1: For any ratio N in 1024..32767 on `ratio_i`, consecutive output pulses are exactly N input cycles apart, where N = 32·N[14:5] + N[4:0].
- R2: The dual-modulus stage counts 33 input cycles while the swallow count (loaded from N[4:0]) is nonzero and 32 cycles once it is zero. A ratio with N[4:0] = 31 is therefore 31 cycles longer than the same N[14:5] with N[4:0] = 0.
- R3: A ratio below 1024, including 0, is treated as 1024.
- R4: The ratio is sampled only on the clock edge that ends an output period. Changing `ratio_i` at any other time leaves the period in progress unchanged and sets the length of the following period.
- R5: `div_pulse_o` is high for exactly one input cycle per period.
- R6: While `rst_n` is low, `div_pulse_o` is low and the counters are loaded from `ratio_i`. The first pulse rises on the N-th rising edge after reset is released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Prescaled input clock, the signal being divided |
| rst_n | input | 1 | Synchronous active-low reset |
| ratio_i | input | 15 | Division ratio N from the control register |
| div_pulse_o | output | 1 | One-cycle pulse per N input cycles |

## Verification
On every cycle, the assertions check the following. The modulus counter never passes its current terminal value. The swallow count never underflows or moves between modulus cycles. The main count stays at or above its floor and always exceeds the swallow count. The output pulse never lasts two cycles. Exact period lengths can only be shown by the bench's scenarios, which measure the spacing between pulses. These scenarios cover clamped ratios, the extreme swallow values, the largest ratio, a ratio change partway through a period, and the first period after reset.

// File: rtl/pulse_swallow_pkg.sv
// Shared default dimensions of the pulse-swallow divider.
package pulse_swallow_pkg;
    localparam int DEF_RATIO_W = 15;   // bits in the division ratio
    localparam int DEF_SWAL_W  = 5;    // low ratio bits steering the swallow count
    localparam int DEF_MIN_RAT = 1024; // smallest ratio accepted
endpackage

// File: rtl/psd_modulus_stage.sv
// Dual-modulus stage: counts 2^SWAL_W+1 input cycles when mod_hi_i is set,
// 2^SWAL_W otherwise, and flags the last cycle of each count on term_o.
// Assumes mod_hi_i only changes on a cycle where term_o was high.
module psd_modulus_stage #(
    parameter int SWAL_W = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic mod_hi_i,
    output logic term_o
);
    localparam int PC_W   = SWAL_W + 1;
    localparam int BASE_M = 1 << SWAL_W;

    logic [PC_W-1:0] phase_q;
    logic [PC_W-1:0] last_val;

    // Pick the final phase value for the active modulus.
    always_comb begin
        last_val = mod_hi_i ? PC_W'(BASE_M) : PC_W'(BASE_M - 1);
        term_o   = (phase_q == last_val);
    end

    // Advance the phase, wrapping after the final value.
    always_ff @(posedge clk) begin
        if (!rst_n)      phase_q <= '0;
        else if (term_o) phase_q <= '0;
        else             phase_q <= phase_q + 1'b1;
    end

    assert_phase_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        phase_q <= PC_W'(BASE_M));
    assert_low_modulus_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !mod_hi_i |-> (phase_q < PC_W'(BASE_M)));
endmodule

// File: rtl/psd_swallow_ctr.sv
// Swallow counter: loaded at each period end, steps down once per modulus
// cycle until it reaches zero, then holds. Nonzero selects the long modulus.
module psd_swallow_ctr #(
    parameter int SWAL_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic              step_i,
    input  logic [SWAL_W-1:0] load_val_i,
    output logic [SWAL_W-1:0] left_o,
    output logic              busy_o
);
    logic [SWAL_W-1:0] left_q;

    // Reload at period end, else count down to zero once per modulus cycle.
    always_ff @(posedge clk) begin
        if (!rst_n || load_i)              left_q <= load_val_i;
        else if (step_i && left_q != '0)   left_q <= left_q - 1'b1;
    end

    assign left_o = left_q;
    assign busy_o = (left_q != '0);

    assert_swallow_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!step_i && !load_i) |=> $stable(left_q));
    assert_swallow_floor_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (left_q == '0 && !load_i) |=> (left_q == '0));
endmodule

// File: rtl/psd_main_ctr.sv
// Main counter: counts modulus cycles from the loaded value down to one and
// signals the final one. Assumes the load value is never below MIN_VAL >= 1.
module psd_main_ctr #(
    parameter int MAIN_W  = 10,
    parameter int MIN_VAL = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step_i,
    input  logic [MAIN_W-1:0] load_val_i,
    output logic [MAIN_W-1:0] left_o,
    output logic              period_end_o
);
    logic [MAIN_W-1:0] left_q;

    // Period ends on the modulus cycle that finishes with one count left.
    assign period_end_o = step_i && (left_q == MAIN_W'(1));
    assign left_o       = left_q;

    // Reload at reset or period end, else step down per modulus cycle.
    always_ff @(posedge clk) begin
        if (!rst_n || period_end_o) left_q <= load_val_i;
        else if (step_i)            left_q <= left_q - 1'b1;
    end

    assert_main_nonzero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        left_q != '0);
    assert_main_reload_floor_R3: assert property (@(posedge clk) disable iff (!rst_n)
        period_end_o |=> (left_q >= MAIN_W'(MIN_VAL)));
endmodule

// File: rtl/pulse_swallow_divider.sv
// Pulse-swallow programmable divider: one single-cycle pulse per N input
// cycles, N = 2^SWAL_W * N[high] + N[low]. The ratio is clamped to MIN_RATIO
// and is sampled only at period end (or during reset).
// Assumes MIN_RATIO >> SWAL_W exceeds 2^SWAL_W - 1.
module pulse_swallow_divider
    import pulse_swallow_pkg::*;
#(
    parameter int RATIO_W   = DEF_RATIO_W,
    parameter int SWAL_W    = DEF_SWAL_W,
    parameter int MIN_RATIO = DEF_MIN_RAT
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [RATIO_W-1:0] ratio_i,
    output logic               div_pulse_o
);
    localparam int MAIN_W   = RATIO_W - SWAL_W;
    localparam int MAIN_MIN = MIN_RATIO >> SWAL_W;

    logic [RATIO_W-1:0] ratio_eff;
    logic               mod_term;
    logic               swal_busy;
    logic               period_end;
    logic [SWAL_W-1:0]  swal_left;
    logic [MAIN_W-1:0]  main_left;
    logic               pulse_q;

    // Raise ratios below the floor to the floor.
    always_comb begin
        ratio_eff = (ratio_i < RATIO_W'(MIN_RATIO)) ? RATIO_W'(MIN_RATIO) : ratio_i;
    end

    psd_modulus_stage #(.SWAL_W(SWAL_W)) u_mod (
        .clk      (clk),
        .rst_n    (rst_n),
        .mod_hi_i (swal_busy),
        .term_o   (mod_term)
    );

    psd_swallow_ctr #(.SWAL_W(SWAL_W)) u_swal (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (period_end),
        .step_i     (mod_term),
        .load_val_i (ratio_eff[SWAL_W-1:0]),
        .left_o     (swal_left),
        .busy_o     (swal_busy)
    );

    psd_main_ctr #(.MAIN_W(MAIN_W), .MIN_VAL(MAIN_MIN)) u_main (
        .clk          (clk),
        .rst_n        (rst_n),
        .step_i       (mod_term),
        .load_val_i   (ratio_eff[RATIO_W-1:SWAL_W]),
        .left_o       (main_left),
        .period_end_o (period_end)
    );

    // Register the period-end strobe as the output pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) pulse_q <= 1'b0;
        else        pulse_q <= period_end;
    end

    assign div_pulse_o = pulse_q;

    assert_pulse_width_R5: assert property (@(posedge clk) disable iff (!rst_n)
        div_pulse_o |=> !div_pulse_o);
    assert_swallow_below_main_R1: assert property (@(posedge clk) disable iff (!rst_n)
        MAIN_W'(swal_left) < main_left);
    assert_reset_quiet_R6: assert property (@(posedge clk)
        !rst_n |=> !div_pulse_o);
endmodule

// File: tb/pulse_swallow_divider_test.sv
module pulse_swallow_divider_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [14:0] ratio_i = 15'd1100;
    logic        div_pulse_o;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    int high_run = 0;
    int max_run = 0;
    logic [14:0] cur;   // ratio captured for the period now running

    pulse_swallow_divider uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .ratio_i     (ratio_i),
        .div_pulse_o (div_pulse_o)
    );

    always #4 clk = ~clk;

    function automatic int exp_len(input logic [14:0] r);
        int v = int'(r);
        if (v < 1024) v = 1024;
        return 32 * (v >> 5) + (v & 31);
    endfunction

    task automatic check(input string tag, input int act, input int expv);
        checks++;
        if (act != expv) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    // Pulse-width monitor and watchdog, sampled at the falling edge.
    always @(negedge clk) begin
        cycles++;
        if (rst_n && div_pulse_o) high_run++;
        else high_run = 0;
        if (high_run > max_run) max_run = high_run;
        if (cycles > 195000) begin
            fails++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=<195000", cycles);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    // Count falling edges until the pulse is seen; optionally change ratio midway.
    task automatic wait_pulse(output int n, input int change_at, input logic [14:0] nv);
        n = 0;
        do begin
            @(negedge clk);
            n++;
            if (n == change_at) ratio_i = nv;
        end while (!div_pulse_o && n < 40000);
    endtask

    // Apply r right after a pulse: next period keeps the old ratio, then r.
    task automatic apply(input string tag, input logic [14:0] r);
        int n;
        ratio_i = r;
        wait_pulse(n, 0, 15'd0);
        check("R4 period in progress keeps old ratio", n, exp_len(cur));
        wait_pulse(n, 0, 15'd0);
        check(tag, n, exp_len(r));
        cur = r;
    endtask

    initial begin
        int n;
        int seed;
        seed = $urandom(32'h1234);
        // R6: output quiet in reset
        repeat (5) @(negedge clk);
        check("R6 pulse low in reset", int'(div_pulse_o), 0);
        rst_n = 1'b1;
        cur = 15'd1100;
        wait_pulse(n, 0, 15'd0);
        check("R6 first pulse N edges after reset", n, 1100);

        apply("R3 ratio 0 clamps to 1024", 15'd0);
        apply("R3 ratio 1023 clamps to 1024", 15'd1023);
        apply("R2 swallow 31 (N=1055)", 15'd1055);
        apply("R2 swallow 0 (N=1056)", 15'd1056);
        apply("R1 minimum ratio 1024", 15'd1024);
        apply("R1 ratio 2047", 15'd2047);

        // R4: change mid-period twice; only value held at period end counts
        ratio_i = 15'd3000;
        wait_pulse(n, 400, 15'd1500);
        check("R4 mid-period change ignored", n, exp_len(cur));
        wait_pulse(n, 0, 15'd0);
        check("R4 value at boundary used", n, 1500);
        cur = 15'd1500;

        apply("R1 maximum ratio 32767", 15'd32767);
        apply("R1 return to 1024 after max", 15'd1024);

        for (int i = 0; i < 6; i++) begin
            logic [14:0] r;
            r = 15'(1024 + ($urandom % 2048));
            apply($sformatf("R1 random ratio %0d", r), r);
        end

        check("R5 longest pulse run", max_run, 1);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule